// File: doc/BRIEF.md
# Multi-length delta pattern prefetcher

This block observes a stream of demand block addresses and predicts the blocks likely to be needed next. Memory is split into 4 KB regions of 64 blocks of 64 bytes. A region tag is the block address with its low 6 bits removed, and the low 6 bits are the offset inside the region. A small history buffer tracks the regions that are currently active. For each region it keeps the last offset touched and the three most recent signed deltas between consecutive offsets.

Three delta tables learn which delta follows a given run of one, two or three earlier deltas. When more than one table can answer, the table with the longest matching run wins. A separate offset table learns, for each first-touch offset, the delta that followed it. This lets a region that was never seen before produce a prefetch on its very first access.

Each prediction is fed back as a new history delta, so one access can start a chain of up to four prefetches. The chain emits one prefetch block address per cycle on a valid/ready output. A downstream cache filters duplicates.

Top module: `delta_pf`

## Requirements
- R1: After reset no prefetch is offered (`pf_valid_o` low) until an access has been seen.
- R2: The delta between the first and second access of a region is stored against the first access's offset. A later first touch of any region at that offset offers block `{tag, offset + delta}`.
- R3: On a non-repeated access to a tracked region, the new delta (current offset minus last offset, 7-bit two's complement) trains table L under the key made of the L previous deltas, for each L from 1 to 3 for which that many deltas exist.
- R4: When several delta tables hold an entry for the chain's history, the prediction comes from the longest key. From the second access of a region onward, only the delta tables predict.
- R5: After each accepted prefetch, the predicted delta joins the chain history and the next prediction is made from it. At most four prefetches follow one access.
- R6: A predicted offset below 0 or above 63 ends the chain with no prefetch offered. Every offered block lies in the region of the latest access.
- R7: While `pf_valid_o` is high, `pf_ready_i` is low and no access arrives, the offer and its address hold unchanged.
- R8: An access discards any unfinished chain and starts a new one from its own region state.
- R9: An access to the same block as the previous access of its region trains nothing, leaves the history unchanged and offers no prefetch.
- R10: The history buffer holds four regions with least-recently-used replacement. A region that was evicted is treated as a first touch, with an empty delta history.
- R11: Each delta table holds eight keys with least-recently-used replacement on training. Training an existing key overwrites its delta.
- R12: The first prefetch of a chain is offered in the cycle after the triggering access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Demand access present this cycle |
| acc_blk_i | input | BLK_W | Demand block address: region tag in the upper bits, 6-bit offset in the lower bits |
| pf_valid_o | output | 1 | Prefetch offer valid |
| pf_ready_i | input | 1 | Downstream accepts the offer |
| pf_blk_o | output | BLK_W | Offered prefetch block address |

## Verification
The hold property assumes that the downstream stalls without a new access landing on the same cycle. An access always takes priority over a waiting offer, so the stimulus never expects a hold across an access. The single-chain-count and region properties assume that accesses are sampled only when `acc_valid_i` is high, with any address accepted. The stimulus keeps each access in the region range of its tag and mixes directed training sequences with random offsets, strides, repeats and ready stalls. A behavioural model using queues predicts the offer on every cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_OFF_W  = 6;
  localparam int unsigned PF_DLT_W  = PF_OFF_W + 1;
  localparam int unsigned PF_HIST_N = 3;
  localparam int unsigned PF_DEGREE = 4;

  typedef logic signed [PF_DLT_W-1:0]     pf_delta_t;
  typedef logic [PF_HIST_N-1:0][PF_DLT_W-1:0] pf_hist_t;  // [0] newest
endpackage

// File: rtl/pf_lru_cam.sv
module pf_lru_cam #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned VAL_W = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] rd_key_i,
  output logic             rd_hit_o,
  output logic [VAL_W-1:0] rd_val_o,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [VAL_W-1:0] wr_val_i
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [KEY_W-1:0] key_q [DEPTH];
  logic [VAL_W-1:0] val_q [DEPTH];
  logic [AW-1:0]    age_q [DEPTH];  // 0 = most recent, DEPTH-1 = victim
  logic             wr_hit;
  logic [AW-1:0]    wr_idx, vic_idx, slot;

  always_comb begin
    rd_hit_o = 1'b0;
    rd_val_o = '0;
    wr_hit   = 1'b0;
    wr_idx   = '0;
    vic_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!rd_hit_o && vld_q[i] && key_q[i] == rd_key_i) begin
        rd_hit_o = 1'b1;
        rd_val_o = val_q[i];
      end
      if (!wr_hit && vld_q[i] && key_q[i] == wr_key_i) begin
        wr_hit = 1'b1;
        wr_idx = AW'(i);
      end
      if (age_q[i] == AW'(DEPTH-1)) vic_idx = AW'(i);
    end
    slot = wr_hit ? wr_idx : vic_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age_q[i] <= AW'(i);
        key_q[i] <= '0;
        val_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      vld_q[slot] <= 1'b1;
      key_q[slot] <= wr_key_i;
      val_q[slot] <= wr_val_i;
      for (int i = 0; i < DEPTH; i++) begin
        if (AW'(i) == slot)             age_q[i] <= '0;
        else if (age_q[i] < age_q[slot]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // R10 R11: a write fills at most one new slot and never drops one
  assert_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ($countones(vld_q) >= $past($countones(vld_q))) &&
                ($countones(vld_q) <= $past($countones(vld_q)) + 1));
endmodule

// File: rtl/pf_off_table.sv
module pf_off_table
  import pf_pkg::*;
#(
  parameter int unsigned OFF_W = PF_OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic             rd_vld_o,
  output pf_delta_t        rd_dlt_o,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  pf_delta_t        wr_dlt_i
);
  localparam int unsigned OFF_N = 1 << OFF_W;

  logic [OFF_N-1:0] vld_q;
  pf_delta_t        dlt_q [OFF_N];

  assign rd_vld_o = vld_q[rd_off_i];
  assign rd_dlt_o = dlt_q[rd_off_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < OFF_N; i++) dlt_q[i] <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_off_i] <= 1'b1;
      dlt_q[wr_off_i] <= wr_dlt_i;
    end
  end
endmodule

// File: rtl/delta_pf.sv
module delta_pf
  import pf_pkg::*;
#(
  parameter int unsigned BLK_W     = 26,
  parameter int unsigned HB_DEPTH  = 4,
  parameter int unsigned DPT_DEPTH = 8,
  parameter int unsigned DEGREE    = PF_DEGREE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [BLK_W-1:0] acc_blk_i,
  output logic             pf_valid_o,
  input  logic             pf_ready_i,
  output logic [BLK_W-1:0] pf_blk_o
);
  localparam int unsigned OFF_W    = PF_OFF_W;
  localparam int unsigned DLT_W    = PF_DLT_W;
  localparam int unsigned HIST_N   = PF_HIST_N;
  localparam int unsigned TAG_W    = BLK_W - OFF_W;
  localparam int unsigned CNT_W    = $clog2(HIST_N + 1);
  localparam int unsigned DEG_W    = $clog2(DEGREE + 1);
  localparam int unsigned HB_VAL_W = OFF_W + HIST_N*DLT_W + CNT_W;

  logic [TAG_W-1:0] acc_tag;
  logic [OFF_W-1:0] acc_off;
  assign {acc_tag, acc_off} = acc_blk_i;

  // region history
  logic                hb_hit;
  logic [HB_VAL_W-1:0] hb_rd, hb_wr;
  logic [OFF_W-1:0]    h_off;
  pf_hist_t            h_hist, new_hist;
  logic [CNT_W-1:0]    h_cnt, new_cnt;
  pf_delta_t           new_dlt;
  logic                zero_dlt, learn;

  assign {h_off, h_hist, h_cnt} = hb_rd;
  assign new_dlt  = {1'b0, acc_off} - {1'b0, h_off};
  assign zero_dlt = hb_hit && (new_dlt == '0);
  assign learn    = acc_valid_i && hb_hit && !zero_dlt;
  assign new_hist = {h_hist[HIST_N-2:0], new_dlt};
  assign new_cnt  = (h_cnt == CNT_W'(HIST_N)) ? h_cnt : h_cnt + 1'b1;

  always_comb begin
    if (!hb_hit)       hb_wr = {acc_off, pf_hist_t'('0), CNT_W'(0)};
    else if (zero_dlt) hb_wr = hb_rd;
    else               hb_wr = {acc_off, new_hist, new_cnt};
  end

  pf_lru_cam #(.KEY_W(TAG_W), .VAL_W(HB_VAL_W), .DEPTH(HB_DEPTH)) u_hist_buf (
    .clk_i, .rst_ni,
    .rd_key_i(acc_tag), .rd_hit_o(hb_hit), .rd_val_o(hb_rd),
    .wr_en_i(acc_valid_i), .wr_key_i(acc_tag), .wr_val_i(hb_wr)
  );

  // prefetch chain state
  logic             ch_act_q;
  logic [TAG_W-1:0] ch_tag_q;
  logic [OFF_W-1:0] ch_off_q;
  pf_hist_t         ch_hist_q;
  logic [CNT_W-1:0] ch_cnt_q;
  logic [DEG_W-1:0] ch_fired_q;

  // first-touch table
  logic      opt_vld;
  pf_delta_t opt_dlt;
  pf_off_table #(.OFF_W(OFF_W)) u_first_tbl (
    .clk_i, .rst_ni,
    .rd_off_i(ch_off_q), .rd_vld_o(opt_vld), .rd_dlt_o(opt_dlt),
    .wr_en_i(learn && h_cnt == '0), .wr_off_i(h_off), .wr_dlt_i(new_dlt)
  );

  // delta tables, key length g+1
  logic [HIST_N-1:0] lk_ok;
  pf_delta_t         lk_dlt [HIST_N];

  for (genvar g = 0; g < HIST_N; g++) begin : g_dtbl
    localparam int unsigned KW = (g + 1) * DLT_W;
    logic [KW-1:0]    tr_key, lk_key;
    logic [DLT_W-1:0] lk_val;
    logic             lk_hit, tr_en;
    assign tr_key = h_hist[g:0];
    assign lk_key = ch_hist_q[g:0];
    assign tr_en  = learn && (h_cnt > CNT_W'(g));
    pf_lru_cam #(.KEY_W(KW), .VAL_W(DLT_W), .DEPTH(DPT_DEPTH)) u_tbl (
      .clk_i, .rst_ni,
      .rd_key_i(lk_key), .rd_hit_o(lk_hit), .rd_val_o(lk_val),
      .wr_en_i(tr_en), .wr_key_i(tr_key), .wr_val_i(new_dlt)
    );
    assign lk_ok[g]  = lk_hit && (ch_cnt_q > CNT_W'(g));
    assign lk_dlt[g] = lk_val;
  end

  // longest key wins: later iterations override
  logic             pr_ok;
  pf_delta_t        pr_d;
  logic [OFF_W+1:0] tgt;
  always_comb begin
    pr_ok = 1'b0;
    pr_d  = '0;
    if (ch_cnt_q == '0) begin
      pr_ok = opt_vld;
      pr_d  = opt_dlt;
    end else begin
      for (int g = 0; g < HIST_N; g++) begin
        if (lk_ok[g]) begin
          pr_ok = 1'b1;
          pr_d  = lk_dlt[g];
        end
      end
    end
  end

  assign tgt        = {2'b00, ch_off_q} + {pr_d[DLT_W-1], pr_d};
  assign pf_valid_o = ch_act_q && pr_ok && (tgt[OFF_W+1:OFF_W] == 2'b00);
  assign pf_blk_o   = {ch_tag_q, tgt[OFF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_act_q   <= 1'b0;
      ch_tag_q   <= '0;
      ch_off_q   <= '0;
      ch_hist_q  <= '0;
      ch_cnt_q   <= '0;
      ch_fired_q <= '0;
    end else if (acc_valid_i) begin
      ch_act_q   <= !zero_dlt;
      ch_tag_q   <= acc_tag;
      ch_off_q   <= acc_off;
      ch_hist_q  <= hb_hit ? new_hist : '0;
      ch_cnt_q   <= hb_hit ? new_cnt : '0;
      ch_fired_q <= '0;
    end else if (ch_act_q) begin
      if (!pf_valid_o) begin
        ch_act_q <= 1'b0;
      end else if (pf_ready_i) begin
        ch_off_q   <= tgt[OFF_W-1:0];
        ch_hist_q  <= {ch_hist_q[HIST_N-2:0], pr_d};
        ch_cnt_q   <= (ch_cnt_q == CNT_W'(HIST_N)) ? ch_cnt_q : ch_cnt_q + 1'b1;
        ch_fired_q <= ch_fired_q + 1'b1;
        if (ch_fired_q == DEG_W'(DEGREE - 1)) ch_act_q <= 1'b0;
      end
    end
  end

  // observation state for the properties below
  logic [BLK_W-1:0] last_blk_q;
  logic             last_vld_q;
  logic [DEG_W-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_blk_q <= '0;
      last_vld_q <= 1'b0;
      seen_q     <= '0;
    end else begin
      if (acc_valid_i) begin
        last_blk_q <= acc_blk_i;
        last_vld_q <= 1'b1;
      end
      if (acc_valid_i)                    seen_q <= '0;
      else if (pf_valid_o && pf_ready_i)  seen_q <= seen_q + 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i && !acc_valid_i) |=> (pf_valid_o && $stable(pf_blk_o)));

  assert_repeat_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && last_vld_q && acc_blk_i == last_blk_q) |=> !pf_valid_o);

  assert_chain_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (seen_q < DEG_W'(DEGREE)));

  assert_in_region_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (last_vld_q && pf_blk_o[BLK_W-1:OFF_W] == last_blk_q[BLK_W-1:OFF_W]));

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_vld_q |-> !pf_valid_o);
endmodule

// File: tb/test_delta_pf.sv
module test_delta_pf;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 26;
  localparam int HB_N  = 4;
  localparam int DPT_N = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             acc_valid_i = 1'b0;
  logic [BLK_W-1:0] acc_blk_i = '0;
  logic             pf_valid_o;
  logic             pf_ready_i = 1'b1;
  logic [BLK_W-1:0] pf_blk_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  delta_pf i_delta_pf (
    .clk_i(clk), .rst_ni, .acc_valid_i, .acc_blk_i,
    .pf_valid_o, .pf_ready_i, .pf_blk_o
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  typedef struct {int tag; int off; int h0; int h1; int h2; int cnt;} reg_t;
  typedef struct {int key; int val;} kv_t;
  reg_t hbq[$];
  kv_t  dq1[$], dq2[$], dq3[$];
  bit   opt_v[64];
  int   opt_d[64];
  bit   m_act = 0;
  int   m_tag, m_off, m_h0, m_h1, m_h2, m_cnt, m_fired;

  function automatic int mkey(int l, int a0, int a1, int a2);
    int k = a0 & 127;
    if (l >= 2) k |= (a1 & 127) << 7;
    if (l >= 3) k |= (a2 & 127) << 14;
    return k;
  endfunction

  function automatic int kfind(input kv_t q[$], input int k);
    foreach (q[i]) if (q[i].key == k) return i;
    return -1;
  endfunction

  task automatic tput(input int t, input int k, input int v);
    kv_t tq[$];
    int  ix;
    case (t) 1: tq = dq1; 2: tq = dq2; default: tq = dq3; endcase
    ix = kfind(tq, k);
    if (ix >= 0) tq.delete(ix);
    tq.push_front('{key: k, val: v});
    if (tq.size() > DPT_N) void'(tq.pop_back());
    case (t) 1: dq1 = tq; 2: dq2 = tq; default: dq3 = tq; endcase
  endtask

  task automatic tget(input int t, input int k, output bit f, output int v);
    kv_t tq[$];
    int  ix;
    case (t) 1: tq = dq1; 2: tq = dq2; default: tq = dq3; endcase
    ix = kfind(tq, k);
    f = (ix >= 0);
    v = f ? tq[ix].val : 0;
  endtask

  task automatic model_pred(output bit ev, output int eb, output int ed);
    bit ok = 0, f;
    int d = 0, v, t;
    ev = 0; eb = 0; ed = 0;
    if (!m_act) return;
    if (m_cnt == 0) begin
      if (opt_v[m_off]) begin ok = 1; d = opt_d[m_off]; end
    end else begin
      for (int l = 3; l >= 1; l--) begin
        if (!ok && m_cnt >= l) begin
          tget(l, mkey(l, m_h0, m_h1, m_h2), f, v);
          if (f) begin ok = 1; d = v; end
        end
      end
    end
    t = m_off + d;
    if (ok && t >= 0 && t < 64) begin ev = 1; eb = m_tag * 64 + t; ed = d; end
  endtask

  task automatic model_step(input bit av, input int blk, input bit rdy, input bit ev, input int ed);
    int   tag, off, ix, d;
    reg_t e;
    if (av) begin
      tag = blk >> 6;
      off = blk & 63;
      ix  = -1;
      foreach (hbq[i]) if (ix < 0 && hbq[i].tag == tag) ix = i;
      m_fired = 0;
      if (ix < 0) begin
        e = '{tag: tag, off: off, h0: 0, h1: 0, h2: 0, cnt: 0};
        hbq.push_front(e);
        if (hbq.size() > HB_N) void'(hbq.pop_back());
        m_act = 1; m_tag = tag; m_off = off; m_cnt = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0;
      end else begin
        e = hbq[ix];
        hbq.delete(ix);
        d = off - e.off;
        if (d == 0) begin
          hbq.push_front(e);
          m_act = 0;
        end else begin
          if (e.cnt == 0) begin opt_v[e.off] = 1; opt_d[e.off] = d; end
          if (e.cnt >= 1) tput(1, mkey(1, e.h0, e.h1, e.h2), d);
          if (e.cnt >= 2) tput(2, mkey(2, e.h0, e.h1, e.h2), d);
          if (e.cnt >= 3) tput(3, mkey(3, e.h0, e.h1, e.h2), d);
          e.h2 = e.h1; e.h1 = e.h0; e.h0 = d;
          e.cnt = (e.cnt < 3) ? e.cnt + 1 : 3;
          e.off = off;
          hbq.push_front(e);
          m_act = 1; m_tag = tag; m_off = off;
          m_h0 = e.h0; m_h1 = e.h1; m_h2 = e.h2; m_cnt = e.cnt;
        end
      end
    end else if (m_act) begin
      if (!ev) m_act = 0;
      else if (rdy) begin
        m_off = m_off + ed;
        m_h2 = m_h1; m_h1 = m_h0; m_h0 = ed;
        m_cnt = (m_cnt < 3) ? m_cnt + 1 : 3;
        m_fired++;
        if (m_fired == 4) m_act = 0;
      end
    end
  endtask

  // ---------------- checking ----------------
  function automatic int seen();
    return pf_valid_o ? int'(pf_blk_o) : -1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive, compare with model, advance model at the edge
  task automatic cycle(input bit av, input int blk, input bit rdy);
    bit ev;
    int eb, ed;
    acc_valid_i = av;
    acc_blk_i   = BLK_W'(blk);
    pf_ready_i  = rdy;
    model_pred(ev, eb, ed);
    chk(cur_req, "model", seen(), ev ? eb : -1);
    @(posedge clk);
    model_step(av, blk, rdy, ev, ed);
    @(negedge clk);
  endtask

  task automatic acc(input int blk);
    cycle(1, blk, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int toff[6];
    int tstr[6];
    for (int i = 0; i < 64; i++) begin opt_v[i] = 0; opt_d[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "in reset", seen(), -1);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    idle(3);
    chk("R1", "idle after reset", seen(), -1);

    // region tag 1, stride 2
    cur_req = "R3";
    acc(64 + 0); idle(6);
    acc(64 + 2); idle(6);
    acc(64 + 4);
    chk("R3", "trained stride", seen(), 64 + 6);
    idle(6);
    acc(64 + 6); idle(6);
    cur_req = "R5";
    acc(64 + 8);
    chk("R12", "first prefetch next cycle", seen(), 64 + 10);
    idle(3);
    chk("R5", "fourth in chain", seen(), 64 + 16);
    idle(1);
    chk("R5", "chain ends after four", seen(), -1);
    idle(3);

    // first-touch learning
    cur_req = "R2";
    acc(128 + 5); idle(4);
    acc(128 + 8); idle(6);
    acc(192 + 5);
    chk("R2", "first touch uses offset table", seen(), 192 + 8);
    idle(4);

    // longest match
    cur_req = "R4";
    acc(256 + 0); idle(6);
    acc(256 + 1); idle(6);
    acc(256 + 2); idle(6);
    acc(256 + 7); idle(6);
    acc(320 + 10); idle(6);
    acc(320 + 13); idle(6);
    acc(320 + 14); idle(6);
    acc(320 + 15);
    chk("R4", "two-delta key beats one-delta key", seen(), 320 + 20);
    idle(6);

    // out of region
    cur_req = "R6";
    acc(384 + 60); idle(4);
    acc(384 + 62);
    chk("R6", "target past region end", seen(), -1);
    idle(3);

    // stall
    cur_req = "R7";
    acc(448 + 20); idle(4);
    acc(448 + 22);
    chk("R7", "offer before stall", seen(), 448 + 24);
    for (int i = 0; i < 3; i++) begin
      cycle(0, 0, 0);
      chk("R7", "held while not ready", seen(), 448 + 24);
    end
    cycle(0, 0, 1);
    chk("R7", "advance after ready", seen(), 448 + 26);

    // abort by new access
    cur_req = "R8";
    acc(448 + 24);
    chk("R8", "restart from new access", seen(), 448 + 26);
    idle(6);

    // repeated block
    cur_req = "R9";
    acc(448 + 24);
    chk("R9", "repeat gives no prefetch", seen(), -1);
    idle(3);

    // eviction of region history
    cur_req = "R10";
    for (int i = 0; i < 4; i++) begin acc((20 + i) * 64 + 40); idle(2); end
    acc(448 + 26);
    chk("R10", "evicted region restarts empty", seen(), -1);
    idle(3);

    // random traffic
    cur_req = "R11";
    for (int i = 0; i < 6; i++) begin toff[i] = $urandom % 64; tstr[i] = ($urandom % 5) - 2; end
    for (int n = 0; n < 4000; n++) begin
      int t;
      bit av, rd;
      t  = $urandom % 6;
      av = ($urandom % 3) == 0;
      rd = ($urandom % 4) != 0;
      if (av) begin
        if (($urandom % 4) != 0) toff[t] = (toff[t] + tstr[t]) & 63;
        else                    toff[t] = (toff[t] + ($urandom % 9) - 4) & 63;
      end
      cycle(av, (40 + t) * 64 + toff[t], rd);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule